// File: doc/BRIEF.md
# Power-on self-test and checksum sequencer

This block runs the start-up sequence of a processor once reset is released. It starts an internal test engine and holds a start request until the engine reports that it is done and whether it passed. After a pass it reads the lowest eight 32-bit words of memory, one at a time, and adds them modulo 2^32. A zero total allows initialization to continue. A failed self-test or a nonzero total latches a failure that only a reset clears.

The failure indicator drives an open-drain pad. The block therefore exposes it as a pull-low enable, `fail_drive_low`: 1 pulls the pad low, which means failure is indicated, and 0 releases the pad. The indicator is on during the self-test. It drops after a pass. It comes back on, and stays on, only if the checksum is bad or the self-test failed. Memory reads use two valid/ready channels. A request is held with a stable address until `rd_req_ready` is sampled high. The response channel raises `rd_rsp_ready` only while the one outstanding read is awaited, and response data offered at any other time is ignored.

Top module: `post_sequencer`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `fail_drive_low`=0, `init_ok`=0, `bist_start`=0 and `rd_req_valid`=0.
- R2: In the first cycle after reset is released, `fail_drive_low`=1 and `bist_start`=1. Both stay at 1 until `bist_done` is sampled high.
- R3: When `bist_done`=1 and `bist_pass`=1 are sampled together, the next cycle shows `fail_drive_low`=0 and `bist_start`=0, and the first read request is issued.
- R4: When `bist_done`=1 and `bist_pass`=0 are sampled together, `fail_drive_low` becomes 1 in the next cycle and stays 1 until reset, and no read request is ever issued.
- R5: Exactly eight read requests are issued, with byte addresses 0, 4, 8 … 28 in ascending order. A request stays valid with a stable address until it is accepted. `rd_rsp_ready` is 1 exactly while one accepted request awaits its response, so that a new request is never valid while a response is outstanding.
- R6: If the eight words sum to zero modulo 2^32, the cycle after the eighth response is accepted shows `init_ok`=1 and `fail_drive_low`=0, and both values hold until reset.
- R7: If the sum is nonzero, the cycle after the eighth response shows `fail_drive_low`=1 and `init_ok`=0, and both values hold until reset.
- R8: Response data offered while `rd_rsp_ready`=0 has no effect on the checksum or on the outcome.
- R9: `init_ok` and `fail_drive_low` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_start | output | 1 | Start request to the test engine, held until done |
| bist_done | input | 1 | Test engine reports completion |
| bist_pass | input | 1 | Test result, valid together with bist_done |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block awaits read data |
| rd_rsp_data | input | 32 | Read data word |
| fail_drive_low | output | 1 | 1 = pull the failure pad low (failure indicated) |
| init_ok | output | 1 | Initialization may continue |

## Verification
The eighth response is added to the running sum in the same cycle as the zero test on the final total. The outcome therefore depends on the look-ahead sum and not on the stored one. The bench provokes this with word sets in which only the last word brings the total to zero or misses zero by one, and with a wrapping pair. It also uses zero response latency, so a response arrives in the first cycle its ready is high. Each outcome is compared with a sum the bench computes itself. The bench also checks `init_ok` and `fail_drive_low` in the very next cycle.

// File: rtl/post_pkg.sv
package post_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELFTEST,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_GOOD,
    ST_BAD
  } post_state_t;
endpackage

// File: rtl/post_fsm.sv
module post_fsm
  import post_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bist_done,
  input  logic        bist_pass,
  input  logic        req_fire,
  input  logic        rsp_fire,
  input  logic        last_word,
  input  logic        total_zero,
  output post_state_t state
);
  post_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     state_nx = ST_SELFTEST;
      ST_SELFTEST: if (bist_done) state_nx = bist_pass ? ST_RD_REQ : ST_BAD;
      ST_RD_REQ:   if (req_fire) state_nx = ST_RD_WAIT;
      ST_RD_WAIT:  if (rsp_fire) begin
                     if (!last_word)      state_nx = ST_RD_REQ;
                     else if (total_zero) state_nx = ST_GOOD;
                     else                 state_nx = ST_BAD;
                   end
      default:     state_nx = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // R6 R7: the final states are terminal until reset
  assert_terminal_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GOOD) |=> (state == ST_GOOD));
  assert_terminal_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BAD) |=> (state == ST_BAD));
endmodule

// File: rtl/post_addr_gen.sv
module post_addr_gen #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 32,
  parameter int STEP      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              last_word
);
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign addr      = ADDR_W'(idx) * ADDR_W'(STEP);
  assign last_word = (idx == IDX_W'(NUM_WORDS - 1));

  // R5: a stalled request keeps its address
  assert_req_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(addr)));
  // R5: addresses stay inside the checked window
  assert_addr_window_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (addr < ADDR_W'(NUM_WORDS * STEP)));
endmodule

// File: rtl/post_accum.sv
module post_accum #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [WORD_W-1:0] data,
  output logic              total_zero
);
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] sum_nx;

  assign sum_nx     = sum + data;
  assign total_zero = (sum_nx == '0);

  always_ff @(posedge clk) begin
    if (rst)         sum <= '0;
    else if (add_en) sum <= sum_nx;
  end

  // R8: the stored sum only moves on an accepted response
  assert_sum_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> $stable(sum));
endmodule

// File: rtl/post_sequencer.sv
module post_sequencer
  import post_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int NUM_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              bist_start,
  input  logic              bist_done,
  input  logic              bist_pass,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              fail_drive_low,
  output logic              init_ok
);
  localparam int STEP = WORD_W / 8;

  post_state_t state;
  logic        req_fire;
  logic        rsp_fire;
  logic        last_word;
  logic        total_zero;

  assign req_fire = rd_req_valid && rd_req_ready;
  assign rsp_fire = rd_rsp_valid && rd_rsp_ready;

  post_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bist_done  (bist_done),
    .bist_pass  (bist_pass),
    .req_fire   (req_fire),
    .rsp_fire   (rsp_fire),
    .last_word  (last_word),
    .total_zero (total_zero),
    .state      (state)
  );

  post_addr_gen #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .STEP      (STEP)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .advance   (rsp_fire),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .addr      (rd_addr),
    .last_word (last_word)
  );

  post_accum #(
    .WORD_W (WORD_W)
  ) u_accum (
    .clk        (clk),
    .rst        (rst),
    .add_en     (rsp_fire),
    .data       (rd_rsp_data),
    .total_zero (total_zero)
  );

  assign bist_start     = (state == ST_SELFTEST);
  assign rd_req_valid   = (state == ST_RD_REQ);
  assign rd_rsp_ready   = (state == ST_RD_WAIT);
  assign init_ok        = (state == ST_GOOD);
  assign fail_drive_low = (state == ST_SELFTEST) || (state == ST_BAD);

  // R1: reset releases every output
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!fail_drive_low && !init_ok && !bist_start && !rd_req_valid));
  // R2: failure is indicated as soon as reset is released
  assert_fail_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (fail_drive_low && bist_start));
  assert_start_implies_fail_R2: assert property (@(posedge clk) disable iff (rst)
    bist_start |-> fail_drive_low);
  // R3: a passing self-test releases the indicator and starts reading
  assert_pass_release_R3: assert property (@(posedge clk) disable iff (rst)
    (bist_start && bist_done && bist_pass) |=> (!fail_drive_low && rd_req_valid));
  // R4: a failing self-test latches failure with no reads
  assert_bist_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (bist_start && bist_done && !bist_pass) |=> (fail_drive_low && !bist_start));
  assert_no_read_in_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (fail_drive_low && !bist_start) |-> !rd_req_valid);
  // R5: one outstanding read at a time
  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_valid && rd_rsp_ready));
  assert_req_to_wait_R5: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> rd_rsp_ready);
  // R6 R7: outcomes are sticky
  assert_init_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    init_ok |=> init_ok);
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fail_drive_low && !bist_start) |=> fail_drive_low);
  // R9: the two outcomes exclude each other
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(init_ok && fail_drive_low));
endmodule

// File: tb/post_sequencer_tb.sv
module post_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bist_start;
  logic        bist_done = 1'b0;
  logic        bist_pass = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        fail_drive_low;
  logic        init_ok;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mem_w [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  post_sequencer dut_i (
    .clk            (clk),
    .rst            (rst),
    .bist_start     (bist_start),
    .bist_done      (bist_done),
    .bist_pass      (bist_pass),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_addr        (rd_addr),
    .rd_rsp_valid   (rd_rsp_valid),
    .rd_rsp_ready   (rd_rsp_ready),
    .rd_rsp_data    (rd_rsp_data),
    .fail_drive_low (fail_drive_low),
    .init_ok        (init_ok)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_sum();
    logic [31:0] s = '0;
    for (int i = 0; i < 8; i++) s = s + mem_w[i];
    return s;
  endfunction

  task automatic stray_rsp();
    rd_rsp_valid = ($urandom_range(0, 1) == 1);
    rd_rsp_data  = $urandom();
  endtask

  task automatic run_case(input bit pass, input int bist_lat, input int ready_gap, input int rsp_lat);
    bit exp_zero;
    bit pending = 0;
    bit bist_over = 0;
    bit chk_after = 0;
    int bcnt = 0;
    int idx_req = 0;
    int k = 0;
    int lat = 0;
    int cyc = 0;
    exp_zero = pass && (mem_sum() == 32'h0);
    rst = 1'b1;
    bist_done = 1'b0;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fail_drive_low && !init_ok && !bist_start && !rd_req_valid, "R1 reset outputs",
        {28'h0, fail_drive_low, init_ok, bist_start, rd_req_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    while (!(bist_over && !chk_after && (!pass || k == 8)) && cyc < 3000) begin
      if (chk_after) begin
        if (pass) chk(!fail_drive_low && !bist_start, "R3 release after pass", {31'h0, fail_drive_low}, 32'h0);
        else      chk(fail_drive_low && !bist_start, "R4 latch after failed self-test", {31'h0, fail_drive_low}, 32'h1);
        chk_after = 0;
      end
      if (!bist_over) begin
        chk(fail_drive_low && bist_start, "R2 indicator during self-test",
            {30'h0, fail_drive_low, bist_start}, 32'h3);
        if (bcnt == bist_lat) begin
          bist_done = 1'b1;
          bist_pass = pass;
          bist_over = 1;
          chk_after = 1;
        end else begin
          bcnt++;
        end
      end else begin
        bist_done = 1'b0;
        bist_pass = ($urandom_range(0, 1) == 1);
      end
      chk(rd_rsp_ready == pending, "R5 response ready only while awaited", {31'h0, rd_rsp_ready}, {31'h0, pending});
      if (pending && rd_rsp_ready) begin
        if (lat == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem_w[k];
          k++;
          pending = 0;
        end else begin
          lat--;
          rd_rsp_valid = 1'b0;
        end
      end else begin
        stray_rsp();
      end
      if (rd_req_valid) begin
        chk(pass, "R4 no request after failed self-test", 32'h1, 32'h0);
        chk(rd_addr == 32'(idx_req * 4), "R5 ascending address", rd_addr, 32'(idx_req * 4));
        chk(!pending && !rd_rsp_ready, "R5 one outstanding read", {31'h0, rd_rsp_ready}, 32'h0);
        rd_req_ready = ($urandom_range(0, ready_gap) == 0);
        if (rd_req_ready) begin
          idx_req++;
          pending = 1;
          lat = $urandom_range(0, rsp_lat);
        end
      end else begin
        rd_req_ready = ($urandom_range(0, 1) == 1);
      end
      @(negedge clk);
      cyc++;
    end
    chk(idx_req == (pass ? 8 : 0), "R5 request count", 32'(idx_req), pass ? 32'd8 : 32'd0);
    for (int i = 0; i < 12; i++) begin
      chk(init_ok == exp_zero, "R6 init continue outcome", {31'h0, init_ok}, {31'h0, exp_zero});
      chk(fail_drive_low == !exp_zero, "R7 sticky failure outcome", {31'h0, fail_drive_low}, {31'h0, !exp_zero});
      chk(!(init_ok && fail_drive_low), "R9 outcomes exclusive", {30'h0, init_ok, fail_drive_low}, 32'h0);
      chk(!rd_req_valid && !bist_start, "R8 no activity after outcome", {30'h0, rd_req_valid, bist_start}, 32'h0);
      stray_rsp();
      bist_done = ($urandom_range(0, 1) == 1);
      rd_req_ready = ($urandom_range(0, 1) == 1);
      @(negedge clk);
    end
    rd_rsp_valid = 1'b0;
    bist_done = 1'b0;
  endtask

  task automatic fill_random(input bit make_zero);
    for (int i = 0; i < 8; i++) mem_w[i] = $urandom();
    if (make_zero) begin
      mem_w[7] = '0;
      mem_w[7] = 32'h0 - mem_sum();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // all zero words: sum zero
    for (int i = 0; i < 8; i++) mem_w[i] = '0;
    run_case(1, 2, 1, 2);
    // wrapping pair sums to zero modulo 2^32
    mem_w[0] = 32'hFFFF_FFFF; mem_w[1] = 32'h1;
    run_case(1, 1, 2, 3);
    // only the last word cancels the total; zero latency everywhere
    fill_random(1);
    run_case(1, 0, 0, 0);
    // one off on the last word
    mem_w[7] = mem_w[7] + 32'h1;
    run_case(1, 3, 0, 0);
    // failed self-test with zero-sum memory
    fill_random(1);
    run_case(0, 4, 1, 1);
    run_case(0, 0, 0, 0);
    // long self-test, heavy back-pressure
    fill_random(1);
    run_case(1, 40, 4, 6);
    for (int r = 0; r < 8; r++) begin
      fill_random(r[0]);
      run_case(1, $urandom_range(0, 10), $urandom_range(0, 3), $urandom_range(0, 4));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule